// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers interrupt sources into a set of identical banks and presents one CPU interrupt line per bank. Each bank holds 32 sticky pending bits that are set by their source inputs. An enable mask gates these bits, and the bank line is raised whenever a pending bit is also enabled. Software finds the source to service by reading the masked status or a per-bank index register. That register gives the highest-numbered source that is both pending and enabled. Software acknowledges a source by writing a one to its pending bit.

Register access uses a 32-bit request/response stream. A request carries a byte address, a write flag and write data. It is accepted on a cycle where `req_valid` and `req_ready` are both high. Every accepted read returns exactly one response on the following cycle. Writes return nothing. If the response is not taken, back-pressure stalls new requests: `req_ready` stays low while `rsp_valid` is high and `rsp_ready` is low. During that stall the response data is held unchanged.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every pending, enable and mode bit is zero, every `irq_o` bit is low and `rsp_valid` is low.
- R2: Bank b occupies byte addresses b*0x28 to b*0x28+0x27. Within a bank, pending is at offset 0x00, enable at 0x08, masked status at 0x10, raw status at 0x18, mode at 0x20 and top-index at 0x24.
- R3: A pending bit is set at every clock edge where its source input is high. It stays set until software clears it.
- R4: Writing to the pending register clears each bit written as one and leaves each bit written as zero unchanged. If a source is high in the cycle of a clearing write, its bit stays set.
- R5: The enable register reads back what was written. The masked status register reads pending AND enable.
- R6: `irq_o[b]` is high exactly when bank b's masked status is nonzero. It rises in the cycle after the edge that captures the source.
- R7: The top-index register returns the valid flag in bit 5 and the index of the highest set masked bit in bits 4:0. It reads all zero when the masked status is zero.
- R8: The raw status register returns the current level of the bank's source inputs.
- R9: The mode register is 32 bits of read/write storage per bank and has no effect on interrupt behaviour.
- R10: The following read as zero and ignore writes: offsets 0x04, 0x0C, 0x14 and 0x1C inside a bank, and any address at or above NUM_BANKS*0x28. Writes to the masked, raw and top-index registers are ignored.
- R11: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. An accepted read raises `rsp_valid` with its data in the next cycle. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_BANKS*SRC_W | Source levels; bank b uses bits b*SRC_W and up |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Read response data |
| irq_o | output | NUM_BANKS | Per-bank CPU interrupt line |

## Verification
Several properties are checked on every cycle: a high source always leaves its pending bit set, a clearing write leaves no cleared bit set unless its source re-asserted, each bank line agrees with the index finder's valid flag, a bank with no enables never raises its line, and a stalled response holds its data. Other behaviours can only be shown by the bench's scenarios. These are the address map and bank stride, the exact index chosen for mixed patterns, raw-status readback, ignored writes to holes and read-only registers, and set-over-clear ordering. The bench sweeps every source of every bank and computes each expected value from the bank and source numbers.

// File: rtl/bicu_pkg.sv
package bicu_pkg;
  localparam int unsigned BANK_STRIDE = 40;
  localparam int unsigned OFS_PEND    = 0;
  localparam int unsigned OFS_EN      = 8;
  localparam int unsigned OFS_MOUT    = 16;
  localparam int unsigned OFS_RAW     = 24;
  localparam int unsigned OFS_MODE    = 32;
  localparam int unsigned OFS_TOP     = 36;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_EN,
    SEL_MOUT,
    SEL_RAW,
    SEL_MODE,
    SEL_TOP
  } reg_sel_e;
endpackage

// File: rtl/bicu_decode.sv
module bicu_decode
  import bicu_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output reg_sel_e             sel_o
);
  int unsigned rel;

  always_comb begin
    hit_o = '0;
    rel   = 0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if ((32'(addr_i) >= 32'(b) * BANK_STRIDE) &&
          (32'(addr_i) < 32'(b + 1) * BANK_STRIDE)) begin
        hit_o[b] = 1'b1;
        rel      = 32'(addr_i) - 32'(b) * BANK_STRIDE;
      end
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o != '0) begin
      case (rel)
        OFS_PEND: sel_o = SEL_PEND;
        OFS_EN:   sel_o = SEL_EN;
        OFS_MOUT: sel_o = SEL_MOUT;
        OFS_RAW:  sel_o = SEL_RAW;
        OFS_MODE: sel_o = SEL_MODE;
        OFS_TOP:  sel_o = SEL_TOP;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bicu_bank.sv
module bicu_bank
  import bicu_pkg::*;
#(
  parameter int SRC_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              hit_i,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(SRC_W);

  logic [SRC_W-1:0]  pend_q, en_q, masked, clr_mask;
  logic [DATA_W-1:0] mode_q;
  logic              top_vld;
  logic [IDX_W-1:0]  top_idx;

  // set beats clear: the source term is ORed after the clear mask
  assign clr_mask = (wr_i && sel_i == SEL_PEND) ? wdata_i[SRC_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | src_i;
      if (wr_i && sel_i == SEL_EN)   en_q   <= wdata_i[SRC_W-1:0];
      if (wr_i && sel_i == SEL_MODE) mode_q <= wdata_i;
    end
  end

  assign masked = pend_q & en_q;
  assign irq_o  = |masked;

  // linear scan, the last hit is the highest index
  always_comb begin
    top_vld = 1'b0;
    top_idx = '0;
    for (int i = 0; i < SRC_W; i++) begin
      if (masked[i]) begin
        top_vld = 1'b1;
        top_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (sel_i)
        SEL_PEND: rdata_o[SRC_W-1:0] = pend_q;
        SEL_EN:   rdata_o[SRC_W-1:0] = en_q;
        SEL_MOUT: rdata_o[SRC_W-1:0] = masked;
        SEL_RAW:  rdata_o[SRC_W-1:0] = src_i;
        SEL_MODE: rdata_o            = mode_q;
        SEL_TOP:  rdata_o[IDX_W:0]   = {top_vld, top_idx};
        default:  rdata_o            = '0;
      endcase
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_PEND) |=>
      ((pend_q & $past(wdata_i[SRC_W-1:0] & ~src_i)) == '0));

  // R6
  irq_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == top_vld);

  // R5
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bicu_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*SRC_W-1:0] src_i,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [NUM_BANKS-1:0]       irq_o
);
  logic [NUM_BANKS-1:0] hit;
  reg_sel_e             sel;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
  logic [DATA_W-1:0]    rd_mux;
  logic                 accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  bicu_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(req_addr),
    .hit_o (hit),
    .sel_o (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bicu_bank #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[b*SRC_W +: SRC_W]),
      .hit_i  (hit[b]),
      .wr_i   (accept && req_write && hit[b]),
      .sel_i  (sel),
      .wdata_i(req_wdata),
      .rdata_o(bank_rd[b]),
      .irq_o  (irq_o[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11
  rsp_birth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctrl;
  localparam int NB = 6;
  localparam int SW = 32;
  localparam int ST = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NB*SW-1:0] src_i = '0;
  logic           req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]     req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           req_ready, rsp_valid;
  logic [31:0]    rsp_rdata;
  logic [NB-1:0]  irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  banked_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(addr); req_wdata = d;
    @(posedge clk); #2;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdreg(input int addr, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(addr);
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    d = rsp_rdata;
  endtask

  function automatic int ra(input int b, input int ofs);
    return b * ST + ofs;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    for (int b = 0; b < NB; b++) begin
      rdreg(ra(b, 0), rd);  chk("R1 pend", rd, 0);
      rdreg(ra(b, 8), rd);  chk("R1 en", rd, 0);
      rdreg(ra(b, 32), rd); chk("R1 mode", rd, 0);
    end

    // R2/R9 stride and mode storage
    for (int b = 0; b < NB; b++) wr(ra(b, 32), 32'hA500_0000 | 32'(b * 32'h1111));
    for (int b = 0; b < NB; b++) begin
      rdreg(ra(b, 32), rd);
      chk("R2 R9 mode readback", rd, 32'hA500_0000 | 32'(b * 32'h1111));
    end

    // R10 holes and out-of-range
    for (int b = 0; b < NB; b++) begin
      for (int h = 4; h < 32; h += 8) begin
        wr(ra(b, h), 32'hFFFF_FFFF);
        rdreg(ra(b, h), rd); chk("R10 hole", rd, 0);
      end
      rdreg(ra(b, 8), rd); chk("R10 en untouched", rd, 0);
    end
    for (int a = NB * ST; a < 256; a += 5) begin
      wr(a, 32'hFFFF_FFFF);
      rdreg(a, rd); chk("R10 beyond", rd, 0);
    end
    chk("R10 no irq", 32'(irq_o), 0);

    // R3 R4 R5 R6 R7 sweep over all sources of all banks
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < SW; s++) begin
        wr(ra(b, 8), 32'(1) << s);
        @(negedge clk); src_i[b*SW+s] = 1'b1;
        @(negedge clk); src_i[b*SW+s] = 1'b0;
        chk("R6 irq up", 32'(irq_o), 32'(1) << b);
        rdreg(ra(b, 0), rd);  chk("R3 pend", rd, 32'(1) << s);
        rdreg(ra(b, 16), rd); chk("R5 masked", rd, 32'(1) << s);
        rdreg(ra(b, 36), rd); chk("R7 top", rd, 32'(32 + s));
        wr(ra(b, 0), 32'(1) << s);
        @(negedge clk);
        chk("R4 irq down", 32'(irq_o), 0);
        rdreg(ra(b, 0), rd); chk("R4 pend clr", rd, 0);
        rdreg(ra(b, 36), rd); chk("R7 top empty", rd, 0);
      end
      wr(ra(b, 8), 0);
    end

    // R5 masking and R7 mixed pattern, bank 2
    @(negedge clk); src_i[2*SW +: SW] = 32'h0081_0014;
    @(negedge clk); src_i[2*SW +: SW] = '0;
    chk("R5 masked no irq", 32'(irq_o), 0);
    rdreg(ra(2, 0), rd);  chk("R3 pend pattern", rd, 32'h0081_0014);
    rdreg(ra(2, 36), rd); chk("R7 none enabled", rd, 0);
    wr(ra(2, 8), 32'h0000_FFFF);
    @(negedge clk);
    chk("R6 irq after enable", 32'(irq_o), 32'h4);
    rdreg(ra(2, 16), rd); chk("R5 masked low", rd, 32'h14);
    rdreg(ra(2, 36), rd); chk("R7 top low", rd, 32'(32 + 4));
    wr(ra(2, 8), 32'hFFFF_FFFF);
    rdreg(ra(2, 8), rd);  chk("R5 en readback", rd, 32'hFFFF_FFFF);
    rdreg(ra(2, 36), rd); chk("R7 top high", rd, 32'(32 + 23));

    // R10 read-only registers ignore writes
    wr(ra(2, 16), 0); wr(ra(2, 36), 0); wr(ra(2, 24), 32'hFFFF_FFFF);
    rdreg(ra(2, 0), rd); chk("R10 ro writes", rd, 32'h0081_0014);

    // R4 partial clear
    wr(ra(2, 0), 32'h0080_0004);
    rdreg(ra(2, 0), rd); chk("R4 partial", rd, 32'h0001_0010);

    // R4 set beats clear
    @(negedge clk);
    src_i[2*SW+16] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(ra(2, 0)); req_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #2;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk); src_i[2*SW+16] = 1'b0;
    rdreg(ra(2, 0), rd); chk("R4 set wins", rd, 32'h0001_0000);
    wr(ra(2, 0), 32'hFFFF_FFFF);
    rdreg(ra(2, 0), rd); chk("R4 all clear", rd, 0);

    // R8 raw status follows live inputs
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); src_i[b*SW +: SW] = 32'h1357_9BDF ^ 32'(b);
      rdreg(ra(b, 24), rd); chk("R8 raw", rd, 32'h1357_9BDF ^ 32'(b));
      @(negedge clk); src_i[b*SW +: SW] = '0;
      wr(ra(b, 0), 32'hFFFF_FFFF);
    end

    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(ra(1, 32));
    @(posedge clk); #2;
    req_addr = 8'(ra(3, 32));
    repeat (3) begin
      @(negedge clk);
      chk("R11 stall valid", 32'(rsp_valid), 1);
      chk("R11 stall ready", 32'(req_ready), 0);
      chk("R11 stall data", rsp_rdata, 32'hA500_1111);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 second data", rsp_rdata, 32'hA500_3333);
    chk("R11 second valid", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R11 drained", 32'(rsp_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule